// File: doc/BRIEF.md
# Calibrated Temperature Code Converter

This block maps values between the 8-bit code produced by an on-die thermal sensor and a temperature in whole degrees Celsius, in either direction. A conversion is requested with a single-cycle `start` pulse. The direction, calibration mode, calibration bytes and operand are sampled on the same edge. The block answers with a one-cycle `done` pulse, an 8-bit result and an error flag. Both outputs then keep their values until the next accepted request completes.

Three calibration modes are offered. The first is a linear interpolation between two factory trim points taken at 25 °C and 85 °C. The second is a single-offset trim. The third is a fixed offset of 50 that needs no trim. Before either trimmed mode uses the low calibration byte, the block checks that byte and replaces it with a supplied fallback if the byte is implausible. The interpolating mode needs a true division, so it runs a one-bit-per-cycle restoring divider. The other modes finish in a single cycle. An optional window check rejects operands that lie outside the range the sensor can measure.

Top module: `tcc_conv`

## Requirements
- R1: After reset, `result` is 0, `err` is 0 and `done` is 0.
- R2: The effective low calibration value is `cal_alt` when `cal_lo` < 40, when `cal_lo` > 100, or when `cal_hi` is nonzero. Otherwise it is `cal_lo`.
- R3: In the fixed mode (`mode` = 2 or 3), `dir` = 0 (temperature to code) gives T + 50, and `dir` = 1 (code to temperature) gives C − 50.
- R4: In the single-trim mode (`mode` = 1), with effective low value e, `dir` = 0 gives T + e − 25 and `dir` = 1 gives C − e + 25.
- R5: In the interpolating mode (`mode` = 0), with effective low value e and h = `cal_hi`, `dir` = 0 gives (T − 25)·(h − e)/60 + e and `dir` = 1 gives (C − e)·60/(h − e) + 25. The quotient is truncated toward zero.
- R6: With `range_en` = 1, a `dir` = 0 operand outside 25..125 or a `dir` = 1 operand outside 75..175 sets `err` = 1 and `result` = 0.
- R7: In the interpolating mode, when `cal_hi` equals the effective low value, the block sets `err` = 1 and `result` = 0 in either direction and does not divide.
- R8: A computed value below 0 is reported as 0, and a value above 255 is reported as 255.
- R9: For single-step results (modes 1 to 3, and any error), `done` is high in the cycle that follows the edge sampling `start`. For interpolated results, `done` rises 2W+3 edges after that edge, which is 19 at W = 8. That count is one edge after the last of the 2W+2 divide steps.
- R10: `done` is high for one cycle per conversion. `result` and `err` change only in a cycle where `done` is high.
- R11: A `start` pulse that arrives while an interpolating conversion is running is ignored. It produces no extra `done` and does not alter the conversion in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request pulse; all other inputs are sampled with it |
| mode | input | 2 | 0 interpolating, 1 single-trim, 2 or 3 fixed offset |
| dir | input | 1 | 0 temperature to code, 1 code to temperature |
| range_en | input | 1 | Enables the operand window check |
| cal_lo | input | W | Low (first) calibration byte |
| cal_hi | input | W | High (second) calibration byte |
| cal_alt | input | W | Fallback substituted for an implausible low byte |
| operand | input | W | Temperature or code to convert |
| result | output | W | Converted, saturated value |
| err | output | 1 | Request rejected |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with its default parameter values: W = 8, trim points 25 and 85, offset 50, fuse window 40..100, and windows 25..125 and 75..175. At these values the dividend fits the 18-bit divider, so every interpolated result takes exactly 19 edges. That fixed count lets the scoreboard check latency to the exact cycle. The 8-bit output width also makes both saturation ends and the negative-quotient truncation reachable with small operands. The fuse window is narrow enough that low, high and nonzero-high substitutions can each be driven separately.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    CAL_INTERP = 2'd0,
    CAL_SINGLE = 2'd1,
    CAL_FIXED  = 2'd2,
    CAL_FIXED2 = 2'd3
  } cal_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } conv_state_e;

endpackage

// File: rtl/tcc_fuse_sel.sv
module tcc_fuse_sel #(
  parameter int W        = 8,
  parameter int FUSE_MIN = 40,
  parameter int FUSE_MAX = 100
) (
  input  logic [W-1:0] cal_lo,
  input  logic [W-1:0] cal_hi,
  input  logic [W-1:0] cal_alt,
  output logic [W-1:0] lo_eff
);

  localparam logic [W-1:0] LIM_LO = W'(FUSE_MIN);
  localparam logic [W-1:0] LIM_HI = W'(FUSE_MAX);

  logic implausible;

  always_comb begin
    implausible = (cal_lo < LIM_LO) || (cal_lo > LIM_HI) || (cal_hi != '0);
    lo_eff      = implausible ? cal_alt : cal_lo;
  end

endmodule

// File: rtl/tcc_prep.sv
module tcc_prep
  import tcc_pkg::*;
#(
  parameter int W       = 8,
  parameter int SW      = 2*W + 2,
  parameter int REF_LO  = 25,
  parameter int REF_HI  = 85,
  parameter int DEF_OFS = 50,
  parameter int T_MIN   = 25,
  parameter int T_MAX   = 125,
  parameter int C_MIN   = 75,
  parameter int C_MAX   = 175
) (
  input  cal_mode_e             mode,
  input  logic                  dir,
  input  logic                  range_en,
  input  logic [W-1:0]          operand,
  input  logic [W-1:0]          lo_eff,
  input  logic [W-1:0]          cal_hi,
  output logic                  bad,
  output logic                  need_div,
  output logic [SW-1:0]         num_mag,
  output logic [SW-1:0]         den_mag,
  output logic                  neg,
  output logic signed [SW-1:0]  bias,
  output logic signed [SW-1:0]  direct_val
);

  localparam logic signed [SW-1:0] REF_LO_S = SW'(REF_LO);
  localparam logic signed [SW-1:0] SPAN_S   = SW'(REF_HI - REF_LO);
  localparam logic signed [SW-1:0] OFS_S    = SW'(DEF_OFS);
  localparam logic [W-1:0] TMIN_U = W'(T_MIN);
  localparam logic [W-1:0] TMAX_U = W'(T_MAX);
  localparam logic [W-1:0] CMIN_U = W'(C_MIN);
  localparam logic [W-1:0] CMAX_U = W'(C_MAX);

  logic signed [SW-1:0] op_s, lo_s, hi_s, a_s, b_s, den_s, prod_s;
  logic                 out_of_win, flat;

  always_comb begin
    op_s = signed'({{(SW-W){1'b0}}, operand});
    lo_s = signed'({{(SW-W){1'b0}}, lo_eff});
    hi_s = signed'({{(SW-W){1'b0}}, cal_hi});

    if (!dir) out_of_win = (operand < TMIN_U) || (operand > TMAX_U);
    else      out_of_win = (operand < CMIN_U) || (operand > CMAX_U);

    flat     = (cal_hi == lo_eff);
    need_div = (mode == CAL_INTERP);
    bad      = (range_en && out_of_win) || (need_div && flat);

    if (!dir) begin
      a_s   = op_s - REF_LO_S;
      b_s   = hi_s - lo_s;
      den_s = SPAN_S;
      bias  = lo_s;
    end else begin
      a_s   = op_s - lo_s;
      b_s   = SPAN_S;
      den_s = hi_s - lo_s;
      bias  = REF_LO_S;
    end
    prod_s  = a_s * b_s;
    neg     = prod_s[SW-1] ^ den_s[SW-1];
    num_mag = prod_s[SW-1] ? SW'(-prod_s) : SW'(prod_s);
    den_mag = den_s[SW-1]  ? SW'(-den_s)  : SW'(den_s);

    unique case (mode)
      CAL_SINGLE: direct_val = dir ? (op_s - lo_s + REF_LO_S) : (op_s + lo_s - REF_LO_S);
      default:    direct_val = dir ? (op_s - OFS_S) : (op_s + OFS_S);
    endcase
  end

endmodule

// File: rtl/tcc_rdiv.sv
module tcc_rdiv #(
  parameter int NW = 18,
  parameter int DW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [NW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [NW-1:0] quot,
  output logic          last
);

  localparam int CW = (NW > 1) ? $clog2(NW) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(NW - 1);

  logic [NW-1:0] q_r, q_n;
  logic [DW-1:0] rem_r, rem_n, den_r, den_n;
  logic [CW-1:0] cnt_r, cnt_n;
  logic          run_r, run_n;
  logic [DW:0]   rem_sh;
  logic          fits;

  always_comb begin
    rem_sh = {rem_r, q_r[NW-1]};
    fits   = (rem_sh >= {1'b0, den_r});
    last   = run_r && (cnt_r == LAST_CNT);

    q_n   = q_r;
    rem_n = rem_r;
    den_n = den_r;
    cnt_n = cnt_r;
    run_n = run_r;
    if (load) begin
      q_n   = dividend;
      rem_n = '0;
      den_n = divisor;
      cnt_n = '0;
      run_n = 1'b1;
    end else if (run_r) begin
      q_n   = {q_r[NW-2:0], fits};
      rem_n = fits ? DW'(rem_sh - {1'b0, den_r}) : DW'(rem_sh);
      cnt_n = cnt_r + 1'b1;
      if (last) run_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r   <= '0;
      rem_r <= '0;
      den_r <= '0;
      cnt_r <= '0;
      run_r <= 1'b0;
    end else begin
      q_r   <= q_n;
      rem_r <= rem_n;
      den_r <= den_n;
      cnt_r <= cnt_n;
      run_r <= run_n;
    end
  end

  assign quot = q_r;

endmodule

// File: rtl/tcc_conv.sv
module tcc_conv
  import tcc_pkg::*;
#(
  parameter int W        = 8,
  parameter int REF_LO   = 25,
  parameter int REF_HI   = 85,
  parameter int DEF_OFS  = 50,
  parameter int FUSE_MIN = 40,
  parameter int FUSE_MAX = 100,
  parameter int T_MIN    = 25,
  parameter int T_MAX    = 125,
  parameter int C_MIN    = 75,
  parameter int C_MAX    = 175
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   mode,
  input  logic         dir,
  input  logic         range_en,
  input  logic [W-1:0] cal_lo,
  input  logic [W-1:0] cal_hi,
  input  logic [W-1:0] cal_alt,
  input  logic [W-1:0] operand,
  output logic [W-1:0] result,
  output logic         err,
  output logic         done
);

  localparam int SW = 2*W + 2;
  localparam logic signed [SW-1:0] MAXV = SW'((1 << W) - 1);

  logic [1:0] rst_sync;
  logic       rst_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  logic [W-1:0]         lo_eff;
  logic                 bad, need_div, neg;
  logic [SW-1:0]        num_mag, den_mag, quot;
  logic signed [SW-1:0] bias, direct_val;
  logic                 div_load, div_last;

  tcc_fuse_sel #(.W(W), .FUSE_MIN(FUSE_MIN), .FUSE_MAX(FUSE_MAX)) u_fuse (
    .cal_lo (cal_lo),
    .cal_hi (cal_hi),
    .cal_alt(cal_alt),
    .lo_eff (lo_eff)
  );

  tcc_prep #(
    .W(W), .SW(SW), .REF_LO(REF_LO), .REF_HI(REF_HI), .DEF_OFS(DEF_OFS),
    .T_MIN(T_MIN), .T_MAX(T_MAX), .C_MIN(C_MIN), .C_MAX(C_MAX)
  ) u_prep (
    .mode      (cal_mode_e'(mode)),
    .dir       (dir),
    .range_en  (range_en),
    .operand   (operand),
    .lo_eff    (lo_eff),
    .cal_hi    (cal_hi),
    .bad       (bad),
    .need_div  (need_div),
    .num_mag   (num_mag),
    .den_mag   (den_mag),
    .neg       (neg),
    .bias      (bias),
    .direct_val(direct_val)
  );

  tcc_rdiv #(.NW(SW), .DW(SW)) u_div (
    .clk     (clk),
    .rst_n   (rst_q),
    .load    (div_load),
    .dividend(num_mag),
    .divisor (den_mag),
    .quot    (quot),
    .last    (div_last)
  );

  function automatic logic [W-1:0] clamp(input logic signed [SW-1:0] v);
    if (v < 0)         return '0;
    else if (v > MAXV) return '1;
    else               return v[W-1:0];
  endfunction

  conv_state_e          st_r, st_n;
  logic [W-1:0]         res_r, res_n;
  logic                 err_r, err_n, done_r, done_n, neg_r, neg_n;
  logic signed [SW-1:0] bias_r, bias_n, q_s;
  logic                 busy;

  always_comb begin
    st_n     = st_r;
    res_n    = res_r;
    err_n    = err_r;
    done_n   = 1'b0;
    neg_n    = neg_r;
    bias_n   = bias_r;
    div_load = 1'b0;
    q_s      = neg_r ? -signed'(quot) : signed'(quot);
    unique case (st_r)
      ST_IDLE: if (start) begin
        if (bad) begin
          res_n  = '0;
          err_n  = 1'b1;
          done_n = 1'b1;
        end else if (need_div) begin
          div_load = 1'b1;
          neg_n    = neg;
          bias_n   = bias;
          st_n     = ST_DIV;
        end else begin
          res_n  = clamp(direct_val);
          err_n  = 1'b0;
          done_n = 1'b1;
        end
      end
      ST_DIV: if (div_last) st_n = ST_FIN;
      ST_FIN: begin
        res_n  = clamp(q_s + bias_r);
        err_n  = 1'b0;
        done_n = 1'b1;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_r   <= ST_IDLE;
      res_r  <= '0;
      err_r  <= 1'b0;
      done_r <= 1'b0;
      neg_r  <= 1'b0;
      bias_r <= '0;
    end else begin
      st_r   <= st_n;
      res_r  <= res_n;
      err_r  <= err_n;
      done_r <= done_n;
      neg_r  <= neg_n;
      bias_r <= bias_n;
    end
  end

  assign busy   = (st_r != ST_IDLE);
  assign result = res_r;
  assign err    = err_r;
  assign done   = done_r;

endmodule

// File: rtl/tcc_conv_chk.sv
module tcc_conv_chk #(
  parameter int W       = 8,
  parameter int DEF_OFS = 50,
  parameter int T_MIN   = 25
) (
  input logic         clk,
  input logic         rst_q,
  input logic         start,
  input logic [1:0]   mode,
  input logic         dir,
  input logic         range_en,
  input logic [W-1:0] operand,
  input logic [W-1:0] result,
  input logic         err,
  input logic         done,
  input logic         busy
);

  localparam int MAXV = (1 << W) - 1;

  // R10
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !done |-> ($stable(result) && $stable(err)));

  // R6
  range_low_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (start && !busy && range_en && !dir && (int'(operand) < T_MIN)) |=> (done && err));

  // R3
  fixed_map_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (start && !busy && (mode == 2'd2) && !dir && !range_en) |=>
      (done && !err && (int'(result) ==
        ((int'($past(operand)) + DEF_OFS > MAXV) ? MAXV : int'($past(operand)) + DEF_OFS))));

  // R9
  div_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q)
    busy |-> !done);

  // R6
  err_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    err |-> (result == '0));

endmodule

bind tcc_conv tcc_conv_chk #(.W(W), .DEF_OFS(DEF_OFS), .T_MIN(T_MIN)) u_chk (
  .clk     (clk),
  .rst_q   (rst_q),
  .start   (start),
  .mode    (mode),
  .dir     (dir),
  .range_en(range_en),
  .operand (operand),
  .result  (result),
  .err     (err),
  .done    (done),
  .busy    (busy)
);

// File: tb/tcc_conv_test.sv
`timescale 1ns/1ps
module tcc_conv_test;

  localparam int W = 8;
  localparam int DIV_LAT = 2*W + 4;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [1:0]   mode;
  logic         dir;
  logic         range_en;
  logic [W-1:0] cal_lo, cal_hi, cal_alt, operand;
  logic [W-1:0] result;
  logic         err, done;

  tcc_conv uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .dir(dir),
    .range_en(range_en), .cal_lo(cal_lo), .cal_hi(cal_hi), .cal_alt(cal_alt),
    .operand(operand), .result(result), .err(err), .done(done)
  );

  always #2.5 clk = ~clk;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;
  int extra  = 0;

  typedef struct {
    int    res;
    bit    err;
    int    due;
    string tag;
  } exp_t;

  exp_t sb[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  // monitor: pops the scoreboard whenever done is seen
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        extra++;
        check(1'b0, "R10/R11 unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(result) == e.res, {e.tag, " result"}, int'(result), e.res);
        check(err == e.err, {e.tag, " err"}, int'(err), int'(e.err));
        check(cyc == e.due, {e.tag, " latency (R9)"}, cyc, e.due);
      end
    end
  end

  // independent reference model
  task automatic model(input int md, input int dr, input int lo, input int hi,
                       input int alt, input int rng, input int op,
                       output int res, output bit er, output int lat);
    int e, v;
    e   = (lo < 40 || lo > 100 || hi != 0) ? alt : lo;
    er  = 0;
    lat = 1;
    v   = 0;
    if (rng != 0 && (dr == 0 ? (op < 25 || op > 125) : (op < 75 || op > 175))) er = 1;
    else if (md == 0) begin
      if (hi == e) er = 1;
      else begin
        lat = DIV_LAT;
        if (dr == 0) v = ((op - 25) * (hi - e)) / 60 + e;
        else         v = ((op - e) * 60) / (hi - e) + 25;
      end
    end else if (md == 1) v = (dr == 0) ? op + e - 25 : op - e + 25;
    else                  v = (dr == 0) ? op + 50 : op - 50;
    res = er ? 0 : (v < 0 ? 0 : (v > 255 ? 255 : v));
  endtask

  task automatic run(input int md, input int dr, input int lo, input int hi,
                     input int alt, input int rng, input int op, input string tag);
    exp_t e;
    int   r, l;
    bit   x;
    model(md, dr, lo, hi, alt, rng, op, r, x, l);
    @(negedge clk);
    mode = 2'(md); dir = dr[0]; cal_lo = W'(lo); cal_hi = W'(hi);
    cal_alt = W'(alt); range_en = rng[0]; operand = W'(op);
    start = 1'b1;
    e.res = r; e.err = x; e.due = cyc + l; e.tag = tag;
    sb.push_back(e);
    @(negedge clk);
    start = 1'b0;
    while (sb.size() != 0) @(negedge clk);
  endtask

  initial begin
    start = 0; mode = 0; dir = 0; range_en = 0;
    cal_lo = 0; cal_hi = 0; cal_alt = 0; operand = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(result == '0 && !err && !done, "R1 reset state", int'(result) + int'(err) + int'(done), 0);

    // fixed offset mode
    run(2, 0, 0, 0, 0, 0, 30,  "R3 fixed T->C");
    run(3, 1, 0, 0, 0, 0, 100, "R3 fixed C->T mode3");
    run(2, 1, 0, 0, 0, 0, 20,  "R8 fixed C->T low clamp");
    run(2, 0, 0, 0, 0, 0, 250, "R8 fixed T->C high clamp");

    // single trim, valid and substituted fuse bytes
    run(1, 0, 60, 0, 77, 0, 40,  "R4 single T->C");
    run(1, 1, 60, 0, 77, 0, 100, "R4 single C->T");
    run(1, 0, 30, 0, 55, 0, 40,  "R2 fuse below window");
    run(1, 0, 110, 0, 55, 0, 40, "R2 fuse above window");
    run(1, 1, 60, 5, 55, 0, 100, "R2 high byte nonzero");
    run(1, 0, 40, 0, 90, 0, 40,  "R2 fuse at lower edge");

    // interpolating mode
    run(0, 0, 0, 110, 50, 0, 85, "R5 interp T->C exact");
    run(0, 0, 0, 107, 50, 0, 30, "R5 interp T->C truncate");
    run(0, 1, 0, 107, 50, 0, 80, "R5 interp C->T truncate");
    run(0, 1, 0, 107, 50, 0, 40, "R5 interp C->T negative quotient");
    run(0, 0, 0, 107, 50, 0, 10, "R5 interp T->C negative product");
    run(0, 1, 0, 41, 40, 0, 255, "R8 interp high clamp");
    run(0, 1, 0, 30, 80, 0, 200, "R5 interp falling slope");
    run(0, 1, 0, 70, 70, 0, 100, "R7 flat calibration C->T");
    run(0, 0, 0, 70, 70, 0, 50,  "R7 flat calibration T->C");

    // window checks
    run(2, 0, 0, 0, 0, 1, 24,  "R6 T below window");
    run(2, 0, 0, 0, 0, 1, 126, "R6 T above window");
    run(2, 0, 0, 0, 0, 1, 125, "R6 T at upper edge");
    run(2, 1, 0, 0, 0, 1, 74,  "R6 C below window");
    run(2, 1, 0, 0, 0, 1, 175, "R6 C at upper edge");
    run(0, 1, 0, 107, 50, 1, 200, "R6 interp C above window");
    run(2, 0, 0, 0, 0, 0, 24,  "R6 window off passes");

    // hold after completion
    run(1, 0, 60, 0, 0, 0, 90, "R10 before hold");
    begin
      logic [W-1:0] keep;
      keep = result;
      operand = 8'd3; mode = 2'd2;
      repeat (6) @(negedge clk);
      check(result == keep && !err && !done, "R10 result held", int'(result), int'(keep));
    end

    // start during an interpolating conversion
    begin
      exp_t e;
      int   r, l;
      bit   x;
      model(0, 0, 0, 110, 50, 0, 85, r, x, l);
      @(negedge clk);
      mode = 2'd0; dir = 1'b0; cal_lo = 0; cal_hi = 8'd110; cal_alt = 8'd50;
      range_en = 1'b0; operand = 8'd85; start = 1'b1;
      e.res = r; e.err = x; e.due = cyc + l; e.tag = "R11 busy start ignored";
      sb.push_back(e);
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
      mode = 2'd2; operand = 8'd10; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (sb.size() != 0) @(negedge clk);
      repeat (8) @(negedge clk);
      check(extra == 0, "R11 no extra done", extra, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule